// File: doc/BRIEF.md
# Serial Frame Transmitter with Byte Queue

This block turns bytes into asynchronous serial frames. Bytes go into a 64-entry queue through a write port. A shifter takes them out one at a time and sends each one on a single serial line. The line rests high. Each frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The shifter moves by exactly one bit on each pulse of an external bit-rate tick, so the baud rate is set entirely by whatever drives that tick.

Three mode inputs shape each frame: character length, parity kind and stop count. The shifter reads them when it loads a byte, so a change takes effect at the next frame. The block has separate pulse commands to turn the transmitter on and off, a path reset that clears itself, and start and stop commands for a break. It reports the queue as empty or full, raises a trigger flag once the occupancy reaches a programmable level, keeps a sticky flag for dropped writes, and shows when the shifter is busy. A driver treats the transmitter as fully idle when the queue is empty and the busy flag is low.

Top module: `ser_tx_core`

## Requirements
- R1: The line is high when idle. A frame starts with one 0 bit, sends the data least significant bit first, and each bit holds the line for exactly one tick period. The line changes only on a clock edge where `bitTick` is high.
- R2: `modeLen` 2'b00 or 2'b01 gives 8 data bits, 2'b10 gives 7 and 2'b11 gives 6.
- R3: When `modePar[2]` is 1 there is no parity bit. Otherwise a parity bit follows the data: 3'b000 makes the count of ones in data plus parity even, 3'b001 makes it odd, 3'b010 sends a constant 0 and 3'b011 sends a constant 1.
- R4: `modeStop[1]` set to 1 gives two stop bits. Otherwise there is one stop bit. Stop bits are 1.
- R5: The queue holds 64 bytes and sends them in the order written. `fifoFull` is high exactly when 64 bytes are held, and `fifoEmpty` is high exactly when none are held.
- R6: `fifoTrig` is high exactly when the occupancy is greater than or equal to `trigLevel`.
- R7: A write while the queue is full is dropped and sets `txOverflow`. The flag stays set until a path reset.
- R8: `txActive` is high from the tick that loads a frame until the tick that ends its last stop bit.
- R9: `cmdEnable` turns the transmitter on and `cmdDisable` turns it off. If both are given in the same cycle, disable wins. While the transmitter is off, queued bytes stay in the queue and no new frame starts.
- R10: `cmdReset` raises `resetBusy` on the next cycle and holds it for RST_CYCLES cycles (3 by default), after which it clears by itself. While busy, the queue is emptied, the shifter goes idle, `txOverflow` clears and writes are ignored.
- R11: `cmdBreakStart` pulls the line low from the next cycle on, and no new frame starts while the break lasts. After `cmdBreakStop`, the line stays low until the first tick edge that comes after the cycle of the stop command, and then returns high.
- R12: When another byte is waiting as a frame ends, its start bit follows the last stop bit on the very next tick, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle pulse per bit period |
| wrValid | input | 1 | Write strobe into the queue |
| wrData | input | 8 | Byte to queue |
| cmdEnable | input | 1 | Pulse: turn transmitter on |
| cmdDisable | input | 1 | Pulse: turn transmitter off (has priority) |
| cmdReset | input | 1 | Pulse: start path reset |
| cmdBreakStart | input | 1 | Pulse: begin break |
| cmdBreakStop | input | 1 | Pulse: end break at next tick |
| modeLen | input | 2 | Character length code |
| modePar | input | 3 | Parity code |
| modeStop | input | 2 | Stop bit code |
| trigLevel | input | 6 | Occupancy trigger level |
| txLine | output | 1 | Serial output line |
| fifoFull | output | 1 | Queue holds 64 bytes |
| fifoEmpty | output | 1 | Queue holds no bytes |
| fifoTrig | output | 1 | Occupancy at or above trigLevel |
| txActive | output | 1 | Shifter is sending a frame |
| txOverflow | output | 1 | Sticky dropped-write flag |
| resetBusy | output | 1 | Path reset in progress |
| txEnabled | output | 1 | Transmitter on |

## Verification
The assertions check a few rules on every cycle. The occupancy never goes past the depth. A write into a full queue always sets the overflow flag, and that flag stays set until a path reset. A frame never starts when starting is not allowed. A disable command always turns the transmitter off, a reset command always raises the busy flag, and a break start always takes effect. The bench scenarios are needed for everything else. Only they can show the exact bit sequence of each frame under each mode combination, the order of bytes through a full queue, the trigger flag over changing occupancy, frames running back to back, and the precise tick on which a break ends.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic flush;    // path reset in progress
    logic startOk;  // a new frame may be loaded
    logic breakOn;  // force the line low
  } txStrobe_t;
endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int RST_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      cmdEnable,
  input  logic      cmdDisable,
  input  logic      cmdReset,
  input  logic      cmdBreakStart,
  input  logic      cmdBreakStop,
  output txStrobe_t strobe,
  output logic      txEnabled,
  output logic      resetBusy
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic           txOn;
  logic           brkOn;
  logic           brkStopPend;
  logic [RCW-1:0] rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOn        <= 1'b0;
      brkOn       <= 1'b0;
      brkStopPend <= 1'b0;
      rstCnt      <= '0;
    end else begin
      if (cmdDisable)     txOn <= 1'b0;
      else if (cmdEnable) txOn <= 1'b1;

      if (cmdReset)           rstCnt <= RCW'(RST_CYCLES);
      else if (rstCnt != '0)  rstCnt <= rstCnt - 1'b1;

      if (cmdBreakStart) begin
        brkOn       <= 1'b1;
        brkStopPend <= 1'b0;
      end else if (brkStopPend && bitTick) begin
        brkOn       <= 1'b0;
        brkStopPend <= 1'b0;
      end else if (cmdBreakStop && brkOn) begin
        brkStopPend <= 1'b1;
      end
    end
  end

  assign resetBusy      = (rstCnt != '0);
  assign txEnabled      = txOn;
  assign strobe.flush   = resetBusy;
  assign strobe.breakOn = brkOn;
  assign strobe.startOk = txOn && !brkOn && !resetBusy;

  // R9: disable has priority over enable
  a_r9_disable_wins: assert property (@(posedge clk) disable iff (!rstN)
    cmdDisable |=> !txEnabled);
  // R10: reset command always raises busy next cycle
  a_r10_reset_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdReset |=> resetBusy);
  // R11: a break start always takes effect
  a_r11_break_start: assert property (@(posedge clk) disable iff (!rstN)
    cmdBreakStart |=> strobe.breakOn);
endmodule

// File: rtl/ser_tx_dp.sv
module ser_tx_dp
  import ser_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      bitTick,
  input  txStrobe_t                 strobe,
  input  logic                      wrValid,
  input  logic [DW-1:0]             wrData,
  input  logic [1:0]                modeLen,
  input  logic [2:0]                modePar,
  input  logic [1:0]                modeStop,
  input  logic [$clog2(DEPTH)-1:0]  trigLevel,
  output logic                      txLine,
  output logic                      fifoFull,
  output logic                      fifoEmpty,
  output logic                      fifoTrig,
  output logic                      txActive,
  output logic                      txOverflow
);
  localparam int AW  = $clog2(DEPTH);
  localparam int FW  = DW + 4;           // start + data + parity + 2 stop
  localparam int LW  = $clog2(FW + 1);

  // ---------------- queue ----------------
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic          wrAcc, load;

  assign fifoFull  = (count == (AW+1)'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign fifoTrig  = (count >= {1'b0, trigLevel});
  assign wrAcc     = wrValid && !fifoFull && !strobe.flush;

  always_ff @(posedge clk) begin
    if (wrAcc) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      txOverflow <= 1'b0;
    end else if (strobe.flush) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      txOverflow <= 1'b0;
    end else begin
      if (wrAcc) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (load)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({wrAcc, load})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wrValid && fifoFull) txOverflow <= 1'b1;
    end
  end

  // ---------------- frame builder ----------------
  logic [DW-1:0] headData, dataMasked;
  logic [3:0]    nData;
  logic          hasPar, parBit;
  logic [1:0]    nStop;
  logic [FW-1:0] newFrame;
  logic [LW-1:0] newLen;

  assign headData = mem[rdPtr];

  always_comb begin
    case (modeLen)
      2'b10:   nData = 4'd7;
      2'b11:   nData = 4'd6;
      default: nData = 4'd8;
    endcase
    hasPar = !modePar[2];
    nStop  = modeStop[1] ? 2'd2 : 2'd1;
    dataMasked = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nData)) dataMasked[i] = headData[i];
    end
    case (modePar[1:0])
      2'b00:   parBit = ^dataMasked;
      2'b01:   parBit = ~^dataMasked;
      2'b10:   parBit = 1'b0;
      default: parBit = 1'b1;
    endcase
    newFrame = '1;
    newFrame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nData)) newFrame[1+i] = dataMasked[i];
    end
    for (int i = 0; i < FW; i++) begin
      if (hasPar && i == 1 + int'(nData)) newFrame[i] = parBit;
    end
    newLen = LW'(1) + LW'(nData) + LW'(hasPar) + LW'(nStop);
  end

  // ---------------- shifter ----------------
  logic [FW-1:0] frameReg;
  logic [LW-1:0] bitsLeft;

  assign load = bitTick && strobe.startOk && !fifoEmpty && !strobe.flush &&
                (!txActive || bitsLeft == LW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
      bitsLeft <= '0;
      txActive <= 1'b0;
    end else if (strobe.flush) begin
      frameReg <= '1;
      bitsLeft <= '0;
      txActive <= 1'b0;
    end else if (load) begin
      frameReg <= newFrame;
      bitsLeft <= newLen;
      txActive <= 1'b1;
    end else if (bitTick && txActive) begin
      if (bitsLeft > LW'(1)) begin
        frameReg <= {1'b1, frameReg[FW-1:1]};
        bitsLeft <= bitsLeft - 1'b1;
      end else begin
        frameReg <= '1;
        bitsLeft <= '0;
        txActive <= 1'b0;
      end
    end
  end

  assign txLine = !strobe.breakOn && (txActive ? frameReg[0] : 1'b1);

  // R5: occupancy never exceeds the depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= (AW+1)'(DEPTH));
  // R7: a write into a full queue sets the flag
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && fifoFull && !strobe.flush) |=> txOverflow);
  // R7: the flag is sticky until a path reset
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txOverflow && !strobe.flush) |=> txOverflow);
  // R9: no frame starts without permission
  a_r9_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.startOk && !txActive) |=> !txActive);
endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core
  import ser_tx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int RST_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       cmdEnable,
  input  logic       cmdDisable,
  input  logic       cmdReset,
  input  logic       cmdBreakStart,
  input  logic       cmdBreakStop,
  input  logic [1:0] modeLen,
  input  logic [2:0] modePar,
  input  logic [1:0] modeStop,
  input  logic [5:0] trigLevel,
  output logic       txLine,
  output logic       fifoFull,
  output logic       fifoEmpty,
  output logic       fifoTrig,
  output logic       txActive,
  output logic       txOverflow,
  output logic       resetBusy,
  output logic       txEnabled
);
  localparam int AW = $clog2(DEPTH);

  txStrobe_t strobe;

  ser_tx_ctrl #(.RST_CYCLES(RST_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .cmdBreakStart(cmdBreakStart), .cmdBreakStop(cmdBreakStop),
    .strobe(strobe), .txEnabled(txEnabled), .resetBusy(resetBusy)
  );

  ser_tx_dp #(.DEPTH(DEPTH), .DW(8)) i_dp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .strobe(strobe),
    .wrValid(wrValid), .wrData(wrData),
    .modeLen(modeLen), .modePar(modePar), .modeStop(modeStop),
    .trigLevel(AW'(trigLevel)),
    .txLine(txLine), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .fifoTrig(fifoTrig), .txActive(txActive), .txOverflow(txOverflow)
  );
endmodule

// File: tb/test_ser_tx_core.sv
module test_ser_tx_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic cmdEnable = 0, cmdDisable = 0, cmdReset = 0, cmdBreakStart = 0, cmdBreakStop = 0;
  logic [1:0] modeLen = 2'b00;
  logic [2:0] modePar = 3'b111;
  logic [1:0] modeStop = 2'b00;
  logic [5:0] trigLevel = 6'd0;
  logic txLine, fifoFull, fifoEmpty, fifoTrig, txActive, txOverflow, resetBusy, txEnabled;

  ser_tx_core i_ser_tx_core (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrValid(wrValid), .wrData(wrData),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .cmdBreakStart(cmdBreakStart), .cmdBreakStop(cmdBreakStop),
    .modeLen(modeLen), .modePar(modePar), .modeStop(modeStop), .trigLevel(trigLevel),
    .txLine(txLine), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fifoTrig(fifoTrig),
    .txActive(txActive), .txOverflow(txOverflow), .resetBusy(resetBusy), .txEnabled(txEnabled)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0, nFails = 0, frameCount = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fLen(input logic [1:0] l, input logic [2:0] p, input logic [1:0] s);
    int n;
    n = (l == 2'b10) ? 7 : (l == 2'b11) ? 6 : 8;
    return 1 + n + (p[2] ? 0 : 1) + (s[1] ? 2 : 1);
  endfunction

  function automatic logic [11:0] fBits(input logic [7:0] d, input logic [1:0] l,
                                        input logic [2:0] p, input logic [1:0] s);
    logic [11:0] f;
    int n, ones;
    n = (l == 2'b10) ? 7 : (l == 2'b11) ? 6 : 8;
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (!p[2]) begin
      case (p[1:0])
        2'b00: f[1+n] = (ones % 2 == 1);
        2'b01: f[1+n] = (ones % 2 == 0);
        2'b10: f[1+n] = 1'b0;
        default: f[1+n] = 1'b1;
      endcase
    end
    return f;
  endfunction

  // tick generator: one pulse every 4 cycles
  int tickCnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      tickCnt = (tickCnt + 1) % 4;
      bitTick = (tickCnt == 0);
    end
  end

  logic tickAtEdge = 1'b0;
  always @(posedge clk) tickAtEdge <= bitTick;

  // line monitor
  logic [7:0] expQ[$];
  bit monOn = 0, inFrame = 0, wantStart = 0;
  int idx = 0;
  logic [11:0] got;
  always @(negedge clk) begin
    if (monOn && tickAtEdge) begin
      if (!inFrame) begin
        if (wantStart) begin
          check(txLine == 1'b0, "R12 back-to-back start", txLine, 0);
          wantStart = 0;
        end
        if (txLine == 1'b0) begin
          inFrame = 1; idx = 1; got = '1; got[0] = 1'b0;
          check(txActive == 1'b1, "R8 active during frame", txActive, 1);
        end
      end else begin
        got[idx] = txLine;
        idx++;
        if (idx == fLen(modeLen, modePar, modeStop)) begin
          inFrame = 0;
          frameCount++;
          if (expQ.size() == 0) check(0, "R1 unexpected frame", got, 0);
          else begin
            logic [7:0] d;
            logic [11:0] e;
            d = expQ.pop_front();
            e = fBits(d, modeLen, modePar, modeStop);
            check(got == e, "R1 R2 R3 R4 frame bits", got, e);
          end
          if (expQ.size() > 0) wantStart = 1;
        end
      end
    end
  end

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d, input bit track);
    wrData = d; wrValid = 1'b1;
    if (track) expQ.push_back(d);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!(fifoEmpty && !txActive && !inFrame) && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(txLine == 1, "R1 idle high", txLine, 1);
    check(fifoEmpty == 1 && fifoFull == 0, "R5 reset empty", {fifoFull, fifoEmpty}, 1);
    check(txActive == 0 && txOverflow == 0 && resetBusy == 0 && txEnabled == 0,
          "R9 reset state", {txActive, txOverflow, resetBusy, txEnabled}, 0);

    // R9: both commands together -> off
    cmdEnable = 1; cmdDisable = 1; @(negedge clk); cmdEnable = 0; cmdDisable = 0;
    check(txEnabled == 0, "R9 disable wins", txEnabled, 0);
    pulse(cmdEnable);
    check(txEnabled == 1, "R9 enable", txEnabled, 1);

    // random framing
    monOn = 1;
    for (int it = 0; it < 14; it++) begin
      int nb;
      modeLen  = 2'($urandom());
      modePar  = 3'($urandom());
      modeStop = 2'($urandom());
      if (it == 0) begin modeLen = 2'b11; modePar = 3'b000; modeStop = 2'b10; end
      if (it == 1) begin modeLen = 2'b10; modePar = 3'b001; modeStop = 2'b00; end
      nb = 1 + int'($urandom() % 3);
      for (int b = 0; b < nb; b++) writeByte(8'($urandom()), 1);
      waitIdle();
      check(expQ.size() == 0, "R1 all bytes sent", expQ.size(), 0);
      check(txLine == 1 && txActive == 0, "R8 idle after frames", {txLine, txActive}, 2);
    end

    // R9: disabled holds bytes
    modeLen = 2'b00; modePar = 3'b111; modeStop = 2'b00;
    pulse(cmdDisable);
    writeByte(8'hA5, 1);
    repeat (60) @(negedge clk);
    check(txActive == 0 && fifoEmpty == 0 && txLine == 1, "R9 held while off",
          {txActive, fifoEmpty, txLine}, 1);
    pulse(cmdEnable);
    waitIdle();
    check(expQ.size() == 0, "R9 sent after enable", expQ.size(), 0);

    // R5/R6/R7: fill while disabled
    pulse(cmdDisable);
    trigLevel = 6'($urandom());
    for (int i = 1; i <= 64; i++) begin
      writeByte(8'($urandom()), 1);
      check(fifoTrig == (i >= int'(trigLevel)), "R6 trigger level", fifoTrig, i >= int'(trigLevel));
      check(fifoFull == (i == 64), "R5 full flag", fifoFull, i == 64);
      check(fifoEmpty == 0, "R5 not empty", fifoEmpty, 0);
      if (i == 32) trigLevel = 6'd63;
    end
    check(txOverflow == 0, "R7 no overflow yet", txOverflow, 0);
    writeByte(8'hEE, 0);
    check(txOverflow == 1 && fifoFull == 1, "R7 drop sets flag", {txOverflow, fifoFull}, 3);
    frameCount = 0;
    pulse(cmdEnable);
    waitIdle();
    check(frameCount == 64, "R5 order and count", frameCount, 64);
    check(txOverflow == 1, "R7 sticky", txOverflow, 1);

    // R10: path reset
    pulse(cmdDisable);
    writeByte(8'h11, 0); writeByte(8'h22, 0);
    pulse(cmdReset);
    for (int k = 0; k < 3; k++) begin
      check(resetBusy == 1, "R10 busy", resetBusy, 1);
      @(negedge clk);
    end
    check(resetBusy == 0, "R10 self clear", resetBusy, 0);
    check(fifoEmpty == 1 && txOverflow == 0, "R10 flushed", {fifoEmpty, txOverflow}, 2);
    frameCount = 0;
    pulse(cmdEnable);
    repeat (200) @(negedge clk);
    check(frameCount == 0 && txLine == 1, "R10 nothing sent", frameCount, 0);

    // R11: break
    monOn = 0;
    pulse(cmdBreakStart);
    check(txLine == 0, "R11 break low", txLine, 0);
    writeByte(8'h5A, 1);
    repeat (30) @(negedge clk);
    check(txActive == 0 && fifoEmpty == 0, "R11 no start in break", {txActive, fifoEmpty}, 0);
    while (!tickAtEdge) @(negedge clk);
    pulse(cmdBreakStop);
    while (!tickAtEdge) begin
      check(txLine == 0, "R11 low until tick", txLine, 0);
      @(negedge clk);
    end
    check(txLine == 1, "R11 released at tick", txLine, 1);
    monOn = 1;
    waitIdle();
    check(expQ.size() == 0, "R11 frame after break", expQ.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule